// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Generation

This block serialises 8- or 9-bit words onto an asynchronous serial line. One holding register sits in front of the shift register. The line rests high. Each frame carries a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. A new bit is placed on the line at each baud tick, and the tick comes from a rate generator outside the block. When the shifter is free, a write goes straight into it and the holding register stays empty. When a frame is already on the line, the write waits in the holding register and follows that frame with no gap.

Software takes part in a two-step handshake. It reads the status (the `stat_rd` strobe) and then writes the data. A write made without that earlier status read is dropped. A write made while the holding register is full is also dropped, so buffered data is never overwritten. A break request drives the line low in frames of at least fourteen bit times. These frames repeat for as long as the request is held. After the request is released, the block closes the break with the configured number of stop bits. The transmit interrupt follows the holding-empty flag, gated by an enable.

Top module: `sertx_buffered`

## Requirements
- R1: After reset, `tx_line` is 1, `hold_empty` is 1 and `tx_idle` is 1. `tx_irq` then equals `irq_en`.
- R2: A data frame is placed on `tx_line` in this order:
  - a start bit of 0;
  - the data bits, least significant first (8 bits when `cfg_nine`=0, or `wr_data[8:0]` when `cfg_nine`=1);
  - a parity bit, only when `cfg_par_en`=1;
  - the stop bits, each 1 (one stop bit when `cfg_two_stop`=0, two when it is 1).
  
  Each bit lasts one baud-tick period. The start bit begins at the first baud tick after the word is loaded. `tx_line` changes only at a clock edge where `baud_tick` was 1.
- R3: The parity bit makes the count of ones over the data bits and the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R4: A write accepted while no frame is in progress loads the shifter at once, and `hold_empty` stays 1.
- R5: A write accepted during a frame is kept in the holding register and drives `hold_empty` to 0. Its frame starts exactly when the current frame's last stop bit ends.
- R6: A write on `wr_stb` is accepted only when both of these hold:
  - a `stat_rd` strobe has occurred since the last accepted write;
  - `hold_empty` is 1.
  
  Any other write is ignored and produces no frame.
- R7: An accepted write clears `tx_idle`. `tx_idle` is set again when a frame ends and no other frame follows it. `hold_empty`=0 implies `tx_idle`=0.
- R8: While `brk_req` is 1, break frames are sent back to back. Each break frame is 14 bit times of 0 (a start bit plus 13 zero bits). Break frames take priority over buffered data. Once `brk_req` falls, the current break frame completes and is followed by 1 or 2 stop bits (per `cfg_two_stop`), and any buffered word is sent after that.
- R9: `tx_irq` is `irq_en` AND `hold_empty`. Break frames do not change it.
- R10: While `en`=0:
  - `tx_line` is 1, `hold_empty` is 1 and `tx_idle` is 1;
  - any buffered word is discarded;
  - writes are ignored, and no frame appears after `en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | 9 | Word to send (bit 8 used in 9-bit mode) |
| stat_rd | input | 1 | Status read strobe, arms the next write |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| brk_req | input | 1 | Break request |
| irq_en | input | 1 | Transmit interrupt enable |
| tx_line | output | 1 | Serial output, high when idle |
| hold_empty | output | 1 | Holding register can take a word |
| tx_idle | output | 1 | No frame pending since the last frame ended |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
Random word lengths, parity modes, stop counts and data values are decoded from the line and compared with frames built in the bench. This separates bit-order, parity-sense and frame-length faults. Directed patterns cover the following cases:
- A write while idle against a write that lands mid-frame, which separates the bypass path from the buffered path. It also checks the exact start-to-start spacing of back-to-back frames.
- A write with no status read before it, and a write with the holding register full, which show that both are dropped.
- Breaks held across two frames with data queued behind them, which measure the exact low time and the stop-bit tail.
- Disabling in the middle of a frame, which shows that the buffered word is discarded.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int WORD_W    = 9;
    localparam int BRK_ZEROS = 13;
    localparam int FRAME_W   = 16;
    localparam int LEN_W     = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FK_DATA,
        FK_BREAK,
        FK_TAIL
    } fkind_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
        fkind_t             kind;
    } frame_t;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } txcfg_t;

    // Bit 0 leaves the line first; unused high bits stay 1 (stop level).
    function automatic frame_t data_frame(logic [WORD_W-1:0] d, txcfg_t c);
        frame_t f;
        int     n;
        logic   p;
        n      = c.nine ? WORD_W : WORD_W - 1;
        f.bits = '1;
        f.bits[0] = 1'b0;
        p = c.par_odd;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < n) begin
                f.bits[i+1] = d[i];
                p = p ^ d[i];
            end
        end
        if (c.par_en) f.bits[n+1] = p;
        f.len  = LEN_W'(1 + n + (c.par_en ? 1 : 0) + (c.two_stop ? 2 : 1));
        f.kind = FK_DATA;
        return f;
    endfunction

    function automatic frame_t break_frame();
        frame_t f;
        f.bits = '1;
        for (int i = 0; i < 1 + BRK_ZEROS; i++) f.bits[i] = 1'b0;
        f.len  = LEN_W'(1 + BRK_ZEROS);
        f.kind = FK_BREAK;
        return f;
    endfunction

    function automatic frame_t tail_frame(logic two_stop);
        frame_t f;
        f.bits = '1;
        f.len  = two_stop ? LEN_W'(2) : LEN_W'(1);
        f.kind = FK_TAIL;
        return f;
    endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
            data <= '0;
        end else if (push) begin
            full <= 1'b1;
            data <= push_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  logic   load,
    input  frame_t frm_in,
    output logic   busy,
    output logic   done,
    output logic   tx,
    output fkind_t kind
);

    logic               run;
    logic [FRAME_W-1:0] sr;
    logic [LEN_W-1:0]   cnt;

    // Last bit period of the current frame expires on this tick.
    assign done = busy & run & tick & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy <= 1'b0;
            run  <= 1'b0;
            tx   <= 1'b1;
            sr   <= '1;
            cnt  <= '0;
            kind <= FK_DATA;
        end else if (load) begin
            busy <= 1'b1;
            kind <= frm_in.kind;
            cnt  <= frm_in.len - 1'b1;
            if (done) begin
                // chained frame: first bit goes out on this very tick
                run <= 1'b1;
                tx  <= frm_in.bits[0];
                sr  <= frm_in.bits >> 1;
            end else begin
                run <= 1'b0;
                sr  <= frm_in.bits;
            end
        end else if (busy && tick) begin
            if (!run) begin
                run <= 1'b1;
                tx  <= sr[0];
                sr  <= sr >> 1;
            end else if (cnt == '0) begin
                busy <= 1'b0;
                run  <= 1'b0;
                tx   <= 1'b1;
            end else begin
                tx  <= sr[0];
                sr  <= sr >> 1;
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sertx_buffered.sv
module sertx_buffered
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              stat_rd,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              brk_req,
    input  logic              irq_en,
    output logic              tx_line,
    output logic              hold_empty,
    output logic              tx_idle,
    output logic              tx_irq
);

    txcfg_t            cfg;
    logic              armed;
    logic              wr_ok;
    logic              hold_full;
    logic [WORD_W-1:0] hold_data;
    logic              sh_busy;
    logic              sh_done;
    fkind_t            sh_kind;
    logic              slot_free;
    logic              load;
    logic              pop;
    logic              direct;
    logic              push;
    frame_t            nxt;

    assign cfg = '{nine: cfg_nine, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    assign wr_ok     = en & wr_stb & armed & ~hold_full;
    assign slot_free = en & (~sh_busy | sh_done);

    // Next-frame arbitration: break tail, break, buffered word, bypass write.
    always_comb begin
        load   = 1'b0;
        pop    = 1'b0;
        direct = 1'b0;
        nxt    = data_frame(hold_data, cfg);
        if (slot_free) begin
            if (sh_done && sh_kind == FK_BREAK && !brk_req) begin
                load = 1'b1;
                nxt  = tail_frame(cfg.two_stop);
            end else if (brk_req) begin
                load = 1'b1;
                nxt  = break_frame();
            end else if (hold_full) begin
                load = 1'b1;
                pop  = 1'b1;
            end else if (wr_ok) begin
                load   = 1'b1;
                direct = 1'b1;
                nxt    = data_frame(wr_data, cfg);
            end
        end
    end

    assign push = wr_ok & ~direct;

    sertx_holdreg #(.W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .flush     (~en),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .full      (hold_full),
        .data      (hold_data)
    );

    sertx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (baud_tick),
        .load   (load),
        .frm_in (nxt),
        .busy   (sh_busy),
        .done   (sh_done),
        .tx     (tx_line),
        .kind   (sh_kind)
    );

    // Status read arms exactly one data write.
    always_ff @(posedge clk) begin
        if (rst || !en)   armed <= 1'b0;
        else if (wr_ok)   armed <= 1'b0;
        else if (stat_rd) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)              tx_idle <= 1'b1;
        else if (wr_ok)              tx_idle <= 1'b0;
        else if (sh_done && !load)   tx_idle <= 1'b1;
    end

    assign hold_empty = ~hold_full;
    assign tx_irq     = irq_en & hold_empty;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       baud_tick,
    input logic       wr_stb,
    input logic [8:0] wr_data,
    input logic       stat_rd,
    input logic       cfg_nine,
    input logic       cfg_par_en,
    input logic       cfg_par_odd,
    input logic       cfg_two_stop,
    input logic       brk_req,
    input logic       irq_en,
    input logic       tx_line,
    input logic       hold_empty,
    input logic       tx_idle,
    input logic       tx_irq
);

    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(baud_tick)) |-> $stable(tx_line));

    assert_hold_fall_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_empty) |-> $past(wr_stb));

    assert_idle_fall_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_idle) |-> $past(wr_stb));

    assert_buffered_not_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !hold_empty) |-> !tx_idle);

    assert_idle_rise_line_high_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_idle) |-> tx_line);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (tx_line && hold_empty && tx_idle));

endmodule

bind sertx_buffered sertx_checker u_chk (.*);

// File: tb/sertx_buffered_test.sv
`timescale 1ns/1ps
module sertx_buffered_test;

    localparam int BT = 8;

    logic       clk = 1'b0;
    logic       rst, en, baud_tick, wr_stb, stat_rd;
    logic [8:0] wr_data;
    logic       cfg_nine, cfg_par_en, cfg_par_odd, cfg_two_stop, brk_req, irq_en;
    logic       tx_line, hold_empty, tx_idle, tx_irq;

    int tests = 0;
    int fails = 0;
    int cyc_cnt = 0;
    int t_start;
    int tc = 0;

    logic [8:0] rd_d;
    logic       rd_p, rd_ok, rd_got;

    always #4 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    sertx_buffered uut (
        .clk(clk), .rst(rst), .en(en), .baud_tick(baud_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .stat_rd(stat_rd),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .brk_req(brk_req), .irq_en(irq_en),
        .tx_line(tx_line), .hold_empty(hold_empty), .tx_idle(tx_idle), .tx_irq(tx_irq)
    );

    initial begin
        baud_tick = 1'b0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % BT;
            baud_tick = (tc == 0);
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stat_write(input logic [8:0] d);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    function automatic int frame_len();
        return 1 + (cfg_nine ? 9 : 8) + (cfg_par_en ? 1 : 0) + (cfg_two_stop ? 2 : 1);
    endfunction

    function automatic logic exp_parity(input logic [8:0] d);
        logic p;
        p = cfg_par_odd;
        for (int i = 0; i < (cfg_nine ? 9 : 8); i++) p = p ^ d[i];
        return p;
    endfunction

    // Decode one frame at mid-bit points using the current configuration.
    task automatic rx_frame();
        int w;
        rd_d = '0; rd_p = 1'b0; rd_ok = 1'b1; rd_got = 1'b0; w = 0;
        while (tx_line !== 1'b0 && w < 60*BT) begin @(negedge clk); w++; end
        if (tx_line !== 1'b0) return;
        rd_got = 1'b1;
        t_start = cyc_cnt;
        cyc(BT/2 - 1);
        if (tx_line !== 1'b0) rd_ok = 1'b0;
        for (int i = 0; i < (cfg_nine ? 9 : 8); i++) begin
            cyc(BT); rd_d[i] = tx_line;
        end
        if (cfg_par_en) begin cyc(BT); rd_p = tx_line; end
        for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
            cyc(BT); if (tx_line !== 1'b1) rd_ok = 1'b0;
        end
    endtask

    task automatic expect_silence(input int n, input string req);
        bit low;
        low = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_line === 1'b0) low = 1'b1;
        end
        check(!low, req, "line stays high", low, 0);
    endtask

    task automatic wait_low(output int t);
        int w;
        w = 0;
        while (tx_line !== 1'b0 && w < 4*BT) begin @(negedge clk); w++; end
        t = cyc_cnt;
    endtask

    task automatic wait_high(output int t);
        int w;
        w = 0;
        while (tx_line !== 1'b1 && w < 80*BT) begin @(negedge clk); w++; end
        t = cyc_cnt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [8:0] d, m;
        int tA, t0, th, gap;
        void'($urandom(32'h5eed_0123));
        rst = 1'b1; en = 1'b1; wr_stb = 1'b0; stat_rd = 1'b0; wr_data = '0;
        cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        brk_req = 1'b0; irq_en = 1'b1;
        cyc(4);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        check(tx_line === 1'b1, "R1", "tx_line", tx_line, 1);
        check(hold_empty === 1'b1, "R1", "hold_empty", hold_empty, 1);
        check(tx_idle === 1'b1, "R1", "tx_idle", tx_idle, 1);
        check(tx_irq === 1'b1, "R1", "tx_irq", tx_irq, 1);

        // R6 write without prior status read is dropped
        @(negedge clk); wr_stb = 1'b1; wr_data = 9'h055;
        @(negedge clk); wr_stb = 1'b0;
        expect_silence(4*BT, "R6");
        check(tx_idle === 1'b1, "R6", "tx_idle after dropped write", tx_idle, 1);

        // R4 / R7 bypass write, 8N1
        stat_write(9'h0A5);
        check(hold_empty === 1'b1, "R4", "hold_empty after idle write", hold_empty, 1);
        check(tx_idle === 1'b0, "R7", "tx_idle cleared by write", tx_idle, 0);
        rx_frame();
        check(rd_got && rd_d == 9'h0A5, "R2", "8N1 data", rd_d, 9'h0A5);
        check(rd_ok, "R2", "start/stop levels", rd_ok, 1);
        cyc(BT);
        check(tx_idle === 1'b1, "R7", "tx_idle after frame", tx_idle, 1);

        // R5 buffered write, R6 full-register write dropped, R9 irq
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b1;
        stat_write(9'h03C);
        fork
            rx_frame();
            begin
                cyc(2);
                stat_write(9'h0C3);
                check(hold_empty === 1'b0, "R5", "hold_empty after mid-frame write", hold_empty, 0);
                check(tx_irq === 1'b0, "R9", "tx_irq with full holding", tx_irq, 0);
                stat_write(9'h077);
            end
        join
        tA = t_start;
        check(rd_d == 9'h03C && rd_ok, "R2", "8E2 first word", rd_d, 9'h03C);
        check(rd_p == exp_parity(9'h03C), "R3", "even parity", rd_p, exp_parity(9'h03C));
        rx_frame();
        check(rd_d == 9'h0C3, "R5", "buffered word", rd_d, 9'h0C3);
        check(t_start - tA == 12*BT, "R5", "back-to-back spacing", t_start - tA, 12*BT);
        check(hold_empty === 1'b1, "R5", "hold_empty after drain", hold_empty, 1);
        expect_silence(5*BT, "R6");
        check(tx_idle === 1'b1, "R7", "tx_idle after both", tx_idle, 1);

        // Random frames
        for (int it = 0; it < 40; it++) begin
            @(negedge clk);
            cfg_nine     = 1'($urandom);
            cfg_par_en   = 1'($urandom);
            cfg_par_odd  = 1'($urandom);
            cfg_two_stop = 1'($urandom);
            irq_en       = 1'($urandom);
            m = cfg_nine ? 9'h1FF : 9'h0FF;
            d = 9'($urandom) & m;
            stat_write(d);
            rx_frame();
            check(rd_got && rd_d == d, "R2", "random data", rd_d, d);
            check(rd_ok, "R2", "random start/stop", rd_ok, 1);
            if (cfg_par_en)
                check(rd_p == exp_parity(d), "R3", "random parity", rd_p, exp_parity(d));
            check(tx_irq === irq_en, "R9", "irq follows enable", tx_irq, irq_en);
            cyc(BT);
            check(tx_idle === 1'b1, "R7", "random idle", tx_idle, 1);
        end

        // R8 break across two frames with a word queued, two stop bits
        @(negedge clk);
        cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b1; irq_en = 1'b1;
        brk_req = 1'b1;
        wait_low(t0);
        cyc(5*BT);
        stat_write(9'h05A);
        check(hold_empty === 1'b0, "R8", "word waits behind break", hold_empty, 0);
        while (cyc_cnt - t0 < 20*BT) @(negedge clk);
        check(tx_line === 1'b0, "R8", "line low in break", tx_line, 0);
        brk_req = 1'b0;
        wait_high(th);
        check(th - t0 == 28*BT, "R8", "two break frames low time", th - t0, 28*BT);
        rx_frame();
        check(rd_d == 9'h05A, "R8", "word after break", rd_d, 9'h05A);
        gap = t_start - th;
        check(gap == 2*BT, "R8", "two-stop tail", gap, 2*BT);
        cyc(2*BT);

        // R8 / R9 single break frame, one stop bit, irq unaffected
        cfg_two_stop = 1'b0;
        brk_req = 1'b1;
        wait_low(t0);
        cyc(3*BT);
        check(tx_irq === 1'b1, "R9", "irq during break", tx_irq, 1);
        brk_req = 1'b0;
        wait_high(th);
        check(th - t0 == 14*BT, "R8", "single break low time", th - t0, 14*BT);
        cyc(BT + 2);
        check(tx_idle === 1'b1 && tx_line === 1'b1, "R8", "idle after break tail", tx_idle, 1);

        // R10 disable mid-frame discards buffered word
        stat_write(9'h011);
        cyc(2);
        stat_write(9'h022);
        cyc(3*BT);
        en = 1'b0;
        cyc(1);
        check(tx_line === 1'b1, "R10", "tx high when disabled", tx_line, 1);
        check(hold_empty === 1'b1, "R10", "holding flushed", hold_empty, 1);
        check(tx_idle === 1'b1, "R10", "idle when disabled", tx_idle, 1);
        stat_write(9'h033);
        en = 1'b1;
        expect_silence(20*BT, "R10");
        stat_write(9'h044);
        rx_frame();
        check(rd_d == 9'h044, "R10", "works after re-enable", rd_d, 9'h044);

        cyc(2*BT);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule